// File: doc/BRIEF.md
# Multi-Accumulator Register File with Transfer Decode

This block is the register file of a small 16-bit processor core. It holds sixteen accumulators and three index registers, named X, Y and W, where W is a second index register that behaves like Y. Every register is named by one 5-bit select code. The read port and the write port each take their own code, so an ALU operation can read one accumulator and write its result into another. For example, a logic or arithmetic result computed from accumulator 3 can land in accumulator 9 without passing through A.

The block also holds a small decode table and a two-state sequencer. When the sequencer is idle and a transfer request arrives, the opcode is decoded. A register-to-register move, or an increment or decrement of any register, then loads its source and target codes and moves the sequencer into its execute state. On the next edge the result is written back, the sign and zero flags are updated, and the sequencer returns to idle. The ALU and the memory interface sit outside the block. The ALU reads the operand on `src_data` and returns its result on `wr_data` with `load` asserted.

Select codes: 0 is accumulator A, 1 is X, 2 is Y, 3 is W, and codes 4 through 18 are accumulators 1 through 15. Codes 19 through 31 are unused.

Top module: `acc_regfile`

## Requirements
- R1: After reset every register reads zero, `flag_n` and `flag_z` are 0, and `busy` is 0.
- R2: While `busy` is 0, `load` with a valid `dst_sel` writes `wr_data` into that register at the clock edge. `src_data` always shows the register named by `src_sel` combinationally, and the source and destination codes are fully independent.
- R3: If `load` writes the register that `src_sel` names, `src_data` shows the old value during that cycle and the new value only after the edge.
- R4: Unused codes (19 to 31) read as zero on `src_data`. A write to an unused code changes no register and no flag.
- R5: Every accepted write, whether from a load, a transfer or a step, sets `flag_n` to bit 15 of the written value and `flag_z` to whether that value is zero. A cycle with no accepted write leaves both flags unchanged.
- R6: A move opcode has bits [15:10] = 6'b101100, bits [9:5] = destination code and bits [4:0] = source code. When `xfer_req` is seen with `busy` at 0 and both codes valid, `busy` is 1 in the next cycle. At the following edge the destination takes the value the source holds at that edge, and `busy` returns to 0.
- R7: A move whose destination or source code is unused, or any opcode whose bits [15:10] match neither class, is ignored: `busy` stays 0 and no register changes.
- R8: A step opcode has bits [15:10] = 6'b101101, bits [9:5] = target code, and bit 0 selecting increment (0) or decrement (1). It works on any of the 19 registers, wraps modulo 2^16, uses the same two-cycle timing as a move, and is ignored when the target code is unused.
- R9: While `busy` is 1, `load` and `xfer_req` are ignored.
- R10: `idx_x`, `idx_y` and `idx_w` continuously show the registers at codes 1, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 5 | Read select for the operand port |
| dst_sel | input | 5 | Write select for the load path |
| load | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 16 | ALU result to be written |
| xfer_req | input | 1 | Requests decode of `opcode` |
| opcode | input | 16 | Move or step opcode |
| src_data | output | 16 | Operand read through `src_sel` |
| idx_x | output | 16 | Index register X |
| idx_y | output | 16 | Index register Y |
| idx_w | output | 16 | Index register W |
| flag_n | output | 1 | Sign of the last accepted write |
| flag_z | output | 1 | Zero status of the last accepted write |
| busy | output | 1 | Sequencer is in its execute cycle |

## Verification
A wrong register cell is not visible until something reads it. The bench therefore sweeps `src_sel` across all 32 codes after the directed cases and at the end of the random run, and reads a random code after every random operation, so a corruption shows within one operation. A sequencer stuck in, or wrongly entering, its execute state shows on `busy` one cycle after the request. A wrong latched source or target code shows as a wrong value at the destination two cycles after the request. Flag errors show one cycle after the write that should have set them.

// File: rtl/acc_rf_pkg.sv
package acc_rf_pkg;

    // Sequencer states
    typedef enum logic {
        ST_DECODE = 1'b0,
        ST_REG    = 1'b1
    } rf_state_e;

    // Decoded operation kinds
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_MOVE = 2'd1,
        OP_INC  = 2'd2,
        OP_DEC  = 2'd3
    } rf_kind_e;

    // Fixed register codes; accumulators 1.. start at CODE_ACC_BASE
    localparam int CODE_A        = 0;
    localparam int CODE_X        = 1;
    localparam int CODE_Y        = 2;
    localparam int CODE_W        = 3;
    localparam int CODE_ACC_BASE = 4;
    localparam int NUM_INDEX     = 3;

endpackage

// File: rtl/acc_rf_decode.sv
module acc_rf_decode
    import acc_rf_pkg::*;
#(
    parameter int OP_W        = 16,
    parameter int SEL_W       = 5,
    parameter int NUM_REGS    = 19,
    parameter int MOVE_CLASS  = 44,
    parameter int STEP_CLASS  = 45
) (
    input  logic [OP_W-1:0]  opcode,
    output rf_kind_e         dec_kind,
    output logic [SEL_W-1:0] dec_dst,
    output logic [SEL_W-1:0] dec_src
);
    localparam int CLS_W = OP_W - 2 * SEL_W;
    localparam logic [SEL_W-1:0] LAST_CODE = SEL_W'(NUM_REGS - 1);
    localparam logic [CLS_W-1:0] MOVE_C    = CLS_W'(MOVE_CLASS);
    localparam logic [CLS_W-1:0] STEP_C    = CLS_W'(STEP_CLASS);

    logic [CLS_W-1:0] cls;
    logic [SEL_W-1:0] f_dst;
    logic [SEL_W-1:0] f_src;

    always_comb begin
        cls      = opcode[OP_W-1 -: CLS_W];
        f_dst    = opcode[2*SEL_W-1 -: SEL_W];
        f_src    = opcode[SEL_W-1:0];
        dec_kind = OP_NONE;
        dec_dst  = f_dst;
        dec_src  = f_src;
        if (cls == MOVE_C) begin
            if (f_dst <= LAST_CODE && f_src <= LAST_CODE) begin
                dec_kind = OP_MOVE;
            end
        end else if (cls == STEP_C) begin
            if (f_dst <= LAST_CODE) begin
                dec_kind = f_src[0] ? OP_DEC : OP_INC;
            end
            dec_src = f_dst;
        end
    end

endmodule

// File: rtl/acc_rf_bank.sv
module acc_rf_bank
    import acc_rf_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int SEL_W    = 5,
    parameter int NUM_REGS = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEL_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SEL_W-1:0]  rd_a_sel,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [SEL_W-1:0]  rd_b_sel,
    output logic [DATA_W-1:0] rd_b_data,
    output logic [DATA_W-1:0] idx_x,
    output logic [DATA_W-1:0] idx_y,
    output logic [DATA_W-1:0] idx_w
);
    logic [DATA_W-1:0] regs_q [NUM_REGS];
    logic [DATA_W-1:0] regs_d [NUM_REGS];

    // Next-value logic: one cell per register code
    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_cell
        always_comb begin
            regs_d[gi] = regs_q[gi];
            if (we && waddr == SEL_W'(gi)) begin
                regs_d[gi] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REGS; i++) begin
            if (!rst_n) regs_q[i] <= '0;
            else        regs_q[i] <= regs_d[i];
        end
    end

    // Read muxes: codes with no cell fall through to zero
    always_comb begin
        rd_a_data = '0;
        rd_b_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_a_sel == SEL_W'(i)) rd_a_data = regs_q[i];
            if (rd_b_sel == SEL_W'(i)) rd_b_data = regs_q[i];
        end
    end

    assign idx_x = regs_q[CODE_X];
    assign idx_y = regs_q[CODE_Y];
    assign idx_w = regs_q[CODE_W];

endmodule

// File: rtl/acc_rf_ctrl.sv
module acc_rf_ctrl
    import acc_rf_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int SEL_W    = 5,
    parameter int NUM_REGS = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SEL_W-1:0]  dst_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              xfer_req,
    input  rf_kind_e          dec_kind,
    input  logic [SEL_W-1:0]  dec_dst,
    input  logic [SEL_W-1:0]  dec_src,
    input  logic [DATA_W-1:0] rd_b_data,
    output logic              we,
    output logic [SEL_W-1:0]  waddr,
    output logic [DATA_W-1:0] wdata,
    output logic [SEL_W-1:0]  rd_b_sel,
    output logic              busy,
    output logic              flag_n,
    output logic              flag_z
);
    localparam logic [SEL_W-1:0] LAST_CODE = SEL_W'(NUM_REGS - 1);

    typedef struct packed {
        rf_state_e        state;
        rf_kind_e         kind;
        logic [SEL_W-1:0] tgt;
        logic [SEL_W-1:0] org;
        logic             n;
        logic             z;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d    = ctl_q;
        we       = 1'b0;
        waddr    = dst_sel;
        wdata    = wr_data;
        rd_b_sel = (ctl_q.kind == OP_MOVE) ? ctl_q.org : ctl_q.tgt;

        unique case (ctl_q.state)
            ST_DECODE: begin
                we = load;
                if (xfer_req && dec_kind != OP_NONE) begin
                    ctl_d.state = ST_REG;
                    ctl_d.kind  = dec_kind;
                    ctl_d.tgt   = dec_dst;
                    ctl_d.org   = dec_src;
                end
            end
            ST_REG: begin
                we    = 1'b1;
                waddr = ctl_q.tgt;
                unique case (ctl_q.kind)
                    OP_INC:  wdata = rd_b_data + DATA_W'(1);
                    OP_DEC:  wdata = rd_b_data - DATA_W'(1);
                    default: wdata = rd_b_data;
                endcase
                ctl_d.state = ST_DECODE;
                ctl_d.kind  = OP_NONE;
            end
            default: ctl_d.state = ST_DECODE;
        endcase

        if (we && waddr <= LAST_CODE) begin
            ctl_d.n = wdata[DATA_W-1];
            ctl_d.z = (wdata == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_DECODE, kind: OP_NONE, tgt: '0, org: '0,
                       n: 1'b0, z: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy   = (ctl_q.state == ST_REG);
    assign flag_n = ctl_q.n;
    assign flag_z = ctl_q.z;

endmodule

// File: rtl/acc_regfile.sv
module acc_regfile
    import acc_rf_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int NUM_ACC    = 16,
    parameter int SEL_W      = 5,
    parameter int OP_W       = 16,
    parameter int MOVE_CLASS = 44,
    parameter int STEP_CLASS = 45
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  src_sel,
    input  logic [SEL_W-1:0]  dst_sel,
    input  logic              load,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              xfer_req,
    input  logic [OP_W-1:0]   opcode,
    output logic [DATA_W-1:0] src_data,
    output logic [DATA_W-1:0] idx_x,
    output logic [DATA_W-1:0] idx_y,
    output logic [DATA_W-1:0] idx_w,
    output logic              flag_n,
    output logic              flag_z,
    output logic              busy
);
    localparam int NUM_REGS = NUM_ACC + NUM_INDEX;

    rf_kind_e          dec_kind;
    logic [SEL_W-1:0]  dec_dst;
    logic [SEL_W-1:0]  dec_src;
    logic              we;
    logic [SEL_W-1:0]  waddr;
    logic [DATA_W-1:0] wdata;
    logic [SEL_W-1:0]  rd_b_sel;
    logic [DATA_W-1:0] rd_b_data;

    acc_rf_decode #(
        .OP_W(OP_W), .SEL_W(SEL_W), .NUM_REGS(NUM_REGS),
        .MOVE_CLASS(MOVE_CLASS), .STEP_CLASS(STEP_CLASS)
    ) decode_i (
        .opcode  (opcode),
        .dec_kind(dec_kind),
        .dec_dst (dec_dst),
        .dec_src (dec_src)
    );

    acc_rf_ctrl #(
        .DATA_W(DATA_W), .SEL_W(SEL_W), .NUM_REGS(NUM_REGS)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .dst_sel  (dst_sel),
        .wr_data  (wr_data),
        .xfer_req (xfer_req),
        .dec_kind (dec_kind),
        .dec_dst  (dec_dst),
        .dec_src  (dec_src),
        .rd_b_data(rd_b_data),
        .we       (we),
        .waddr    (waddr),
        .wdata    (wdata),
        .rd_b_sel (rd_b_sel),
        .busy     (busy),
        .flag_n   (flag_n),
        .flag_z   (flag_z)
    );

    acc_rf_bank #(
        .DATA_W(DATA_W), .SEL_W(SEL_W), .NUM_REGS(NUM_REGS)
    ) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (we),
        .waddr    (waddr),
        .wdata    (wdata),
        .rd_a_sel (src_sel),
        .rd_a_data(src_data),
        .rd_b_sel (rd_b_sel),
        .rd_b_data(rd_b_data),
        .idx_x    (idx_x),
        .idx_y    (idx_y),
        .idx_w    (idx_w)
    );

endmodule

// File: rtl/acc_regfile_chk.sv
module acc_regfile_chk #(
    parameter int DATA_W   = 16,
    parameter int SEL_W    = 5,
    parameter int NUM_REGS = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SEL_W-1:0]  src_sel,
    input logic [SEL_W-1:0]  dst_sel,
    input logic              load,
    input logic [DATA_W-1:0] wr_data,
    input logic              xfer_req,
    input logic [DATA_W-1:0] src_data,
    input logic [DATA_W-1:0] idx_x,
    input logic [DATA_W-1:0] idx_y,
    input logic [DATA_W-1:0] idx_w,
    input logic              flag_n,
    input logic              flag_z,
    input logic              busy
);
    localparam logic [SEL_W-1:0] LAST_CODE = SEL_W'(NUM_REGS - 1);

    // R6: the execute state lasts exactly one cycle
    p_busy_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R6: the execute state is entered only after a request
    p_busy_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(xfer_req));

    // R4: unused codes read as zero
    p_unused_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel > LAST_CODE) |-> (src_data == '0));

    // R5: no accepted write, no flag change
    p_flags_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(load && dst_sel <= LAST_CODE)) |=> $stable({flag_n, flag_z}));

    // R5: zero flag follows the loaded value
    p_zero_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && load && dst_sel <= LAST_CODE) |=> (flag_z == ($past(wr_data) == '0)));

    // R5: sign flag follows the loaded value
    p_sign_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && load && dst_sel <= LAST_CODE) |=> (flag_n == $past(wr_data[DATA_W-1])));

    // R10: index outputs hold when nothing can write them
    p_idx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load) |=> ($stable(idx_x) && $stable(idx_y) && $stable(idx_w)));

endmodule

bind acc_regfile acc_regfile_chk #(
    .DATA_W(DATA_W), .SEL_W(SEL_W), .NUM_REGS(NUM_REGS)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_sel (src_sel),
    .dst_sel (dst_sel),
    .load    (load),
    .wr_data (wr_data),
    .xfer_req(xfer_req),
    .src_data(src_data),
    .idx_x   (idx_x),
    .idx_y   (idx_y),
    .idx_w   (idx_w),
    .flag_n  (flag_n),
    .flag_z  (flag_z),
    .busy    (busy)
);

// File: tb/acc_regfile_tb_top.sv
module acc_regfile_tb_top;
    localparam int NREG  = 19;
    localparam int NCODE = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  src_sel = '0;
    logic [4:0]  dst_sel = '0;
    logic        load = 1'b0;
    logic [15:0] wr_data = '0;
    logic        xfer_req = 1'b0;
    logic [15:0] opcode = '0;
    logic [15:0] src_data, idx_x, idx_y, idx_w;
    logic        flag_n, flag_z, busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] m_reg [NCODE];
    logic        m_n, m_z;

    always #4 clk = ~clk;

    acc_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .dst_sel(dst_sel),
        .load(load), .wr_data(wr_data), .xfer_req(xfer_req), .opcode(opcode),
        .src_data(src_data), .idx_x(idx_x), .idx_y(idx_y), .idx_w(idx_w),
        .flag_n(flag_n), .flag_z(flag_z), .busy(busy)
    );

    function automatic logic [15:0] m_read(input logic [4:0] s);
        return (int'(s) < NREG) ? m_reg[s] : 16'h0000;
    endfunction

    function automatic logic [15:0] mk_move(input logic [4:0] d, input logic [4:0] s);
        return {6'b101100, d, s};
    endfunction

    function automatic logic [15:0] mk_step(input logic [4:0] t, input bit dn);
        return {6'b101101, t, 4'b0000, dn};
    endfunction

    task automatic m_write(input logic [4:0] s, input logic [15:0] v);
        if (int'(s) < NREG) begin
            m_reg[s] = v;
            m_n = v[15];
            m_z = (v == 16'h0000);
        end
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_state(input string tag);
        check({tag, " flag_n"}, 32'(flag_n), 32'(m_n));
        check({tag, " flag_z"}, 32'(flag_z), 32'(m_z));
        check("R10 idx_x", 32'(idx_x), 32'(m_reg[1]));
        check("R10 idx_y", 32'(idx_y), 32'(m_reg[2]));
        check("R10 idx_w", 32'(idx_w), 32'(m_reg[3]));
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < NCODE; i++) begin
            src_sel = 5'(i);
            #1;
            check(tag, 32'(src_data), 32'(m_read(5'(i))));
        end
    endtask

    // R2 / R3 / R4 / R5: load through the write port
    task automatic do_load(input logic [4:0] d, input logic [15:0] v);
        load = 1'b1; dst_sel = d; wr_data = v; src_sel = d;
        #1;
        check("R3 old value same cycle", 32'(src_data), 32'(m_read(d)));
        step();
        load = 1'b0;
        m_write(d, v);
        check("R2 R4 value after load", 32'(src_data), 32'(m_read(d)));
        check_state("R5");
    endtask

    // R6 / R7 / R8 / R9: decoded operation, optionally disturbed while busy
    task automatic do_op(input logic [15:0] opc, input bit disturb,
                         input logic [4:0] dd, input logic [15:0] dv);
        logic [4:0] d, s;
        int kind;
        logic [15:0] res;
        d = opc[9:5]; s = opc[4:0];
        kind = 0;
        if (opc[15:10] == 6'b101100 && int'(d) < NREG && int'(s) < NREG) kind = 1;
        else if (opc[15:10] == 6'b101101 && int'(d) < NREG) kind = opc[0] ? 3 : 2;
        xfer_req = 1'b1; opcode = opc;
        step();
        xfer_req = 1'b0;
        check("R6 R7 busy after request", 32'(busy), 32'(kind != 0));
        if (kind != 0) begin
            if (disturb) begin
                load = 1'b1; dst_sel = dd; wr_data = dv;
                xfer_req = 1'b1; opcode = mk_move(5'd5, 5'd6);
            end
            case (kind)
                1: res = m_read(s);
                2: res = m_read(d) + 16'd1;
                default: res = m_read(d) - 16'd1;
            endcase
            step();
            load = 1'b0; xfer_req = 1'b0;
            m_write(d, res);
            check("R6 R9 busy cleared", 32'(busy), 32'd0);
        end
        src_sel = d;
        #1;
        check("R6 R7 R8 destination value", 32'(src_data), 32'(m_read(d)));
        check_state("R5");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog R6 actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < NCODE; i++) m_reg[i] = 16'h0000;
        m_n = 1'b0; m_z = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 busy", 32'(busy), 32'd0);
        check_state("R1");
        sweep("R1 reset read");

        // Directed cases
        do_load(5'd0, 16'h8001);                     // R2 A, R5 n=1
        do_load(5'd18, 16'h0000);                    // R5 z=1, last accumulator
        do_load(5'd25, 16'h1234);                    // R4 unused write ignored
        check("R4 flags after unused write z", 32'(flag_z), 32'd1);
        do_load(5'd1, 16'h0042);                     // X
        do_op(mk_move(5'd10, 5'd0), 1'b0, 5'd0, 16'h0);  // R6 A -> acc7
        do_op(mk_move(5'd5, 5'd1), 1'b0, 5'd0, 16'h0);   // R6 X -> acc2
        do_op(mk_move(5'd3, 5'd5), 1'b0, 5'd0, 16'h0);   // R6 acc -> W, R10
        do_op(mk_move(5'd20, 5'd0), 1'b0, 5'd0, 16'h0);  // R7 bad dst
        do_op(mk_move(5'd4, 5'd30), 1'b0, 5'd0, 16'h0);  // R7 bad src
        do_op(16'h1234, 1'b0, 5'd0, 16'h0);              // R7 other class
        do_load(5'd7, 16'hFFFF);
        do_op(mk_step(5'd7, 1'b0), 1'b0, 5'd0, 16'h0);   // R8 wrap to 0, z=1
        do_op(mk_step(5'd7, 1'b1), 1'b0, 5'd0, 16'h0);   // R8 wrap to FFFF, n=1
        do_op(mk_step(5'd2, 1'b0), 1'b0, 5'd0, 16'h0);   // R8 index Y
        do_op(mk_step(5'd22, 1'b0), 1'b0, 5'd0, 16'h0);  // R8 unused target
        do_op(mk_move(5'd9, 5'd0), 1'b1, 5'd12, 16'hBEEF); // R9 load ignored
        src_sel = 5'd12;
        #1;
        check("R9 register untouched during busy", 32'(src_data), 32'(m_read(5'd12)));
        sweep("R2 directed sweep");

        // Constrained random mix
        for (int it = 0; it < 400; it++) begin
            int pick;
            logic [4:0] a, b;
            logic [15:0] v;
            pick = int'($urandom_range(0, 9));
            a = 5'($urandom_range(0, 22));
            b = 5'($urandom_range(0, 22));
            v = ($urandom_range(0, 7) == 0) ? 16'h0000 : 16'($urandom);
            if (pick < 4)      do_load(a, v);
            else if (pick < 7) do_op(mk_move(a, b), pick == 6, b, v);
            else               do_op(mk_step(a, pick[0]), 1'b0, b, v);
            src_sel = 5'($urandom_range(0, 31));
            #1;
            check("R2 random read", 32'(src_data), 32'(m_read(src_sel)));
        end
        sweep("R2 final sweep");
        check_state("R5 final");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule